// File: doc/BRIEF.md
# Descriptor-Ring Audio Playback DMA Channel

This block is one playback channel of a bus-master audio DMA engine. Software builds a ring of 32 buffer descriptors in memory, each two 32-bit words: a buffer address and a control word. The control word carries a sample count, an interrupt-on-completion request and an underrun pad selection. Software points the channel at the ring, moves a last-valid index ahead of the hardware, and starts the run. The channel then fetches descriptors one after another over a simple read port and hands out the current buffer address for whatever streams the sample data in. It pushes one 16-bit word toward the codec for every accepted handshake, counting each buffer down to zero.

The channel chases the software-owned last-valid index around the ring. When it finishes the buffer at that index it halts and flags the event. Moving the last-valid index on lets it continue with the next entry. Completion, last-valid, index-match and FIFO-error events are sticky status bits that software clears by writing ones. An interrupt line combines them with per-event enables held in the control byte.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset the readable state is: ring base 0, current index 0, last valid index 0, status 0x01 (halted only), position 0, control 0.
- R2: Register map by 32-bit word index `reg_word`. Word 0 holds the ring base, written only with all four byte enables; bits 2:0 read as zero. Word 1 holds the current index in byte 0 (read only), the last valid index in byte 1 and status in byte 2. Word 2 holds the position in bits 15:0 (read only) and control in byte 3. While running, the channel fetches descriptor k with two reads, at base+8k (address word) and then base+8k+4 (control word).
- R3: `buf_addr` presents the fetched address word of the current descriptor with bit 0 forced to zero.
- R4: The position loads the descriptor length (control bits 15:0) and drops by one per accepted sample. A buffer therefore emits exactly that many samples, with `out_data` equal to `in_data` while `in_valid` is high.
- R5: When a buffer that is not at the last valid index completes, the current index advances by one modulo 32 (31 wraps to 0) and the next descriptor is fetched.
- R6: Status bit 3 is set on a completed buffer only when its control bit 31 is set.
- R7: Completing the buffer at the last valid index sets status bit 2 and halts (status bit 0 reads 1, no more samples). Writing a different last valid index resumes at the next index.
- R8: Status bit 1 is set when the current index becomes equal to the last valid index, whether the run or a last-valid write caused it.
- R9: Writing ones to status bits 4..1 clears them; status bit 0 is not affected by writes.
- R10: A sample accepted while `in_valid` is low sets status bit 4. The word sent is the previously sent sample when descriptor bit 30 is set, and zero when it is clear.
- R11: `irq` is high while (status bit 3 and control bit 4), or (status bit 2 and control bit 3), or (status bit 4 and control bit 2).
- R12: Control bit 2 is the run bit. Writing control 0 pauses: control reads back 0, status bit 0 reads 1, no samples move and the position holds. Setting the run bit again continues from the held position.
- R13: Writing control bit 1 clears the current index, position and control (bit 1 itself reads 0) and drops the loaded descriptor. The last valid index and base are kept.
- R14: A descriptor of length 0 completes as soon as its control word arrives, without emitting a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 2 | Register word index |
| reg_be | input | 4 | Byte enables of a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of word `reg_word` (combinational) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| buf_addr | output | 32 | Current buffer address, bit 0 cleared |
| in_valid | input | 1 | Sample data available |
| in_data | input | 16 | Sample from the buffer data feed |
| in_ready | output | 1 | Sample taken this cycle |
| out_valid | output | 1 | Sample offered to the codec |
| out_ready | input | 1 | Codec takes the sample |
| out_data | output | 16 | Sample word |
| irq | output | 1 | Interrupt request |

## Verification
The ring is filled with descriptors whose lengths, completion flags and pad flags are computed from the index, with one zero-length entry. A monitor counts the samples per buffer address. Passes of the main function cover a short run from index 0, a run that wraps from 4 through 31 back to 2, an all-underrun pass over a pad-last and a pad-zero buffer, and a paused and resumed buffer with its position read mid-way. The per-index sample totals separate wrong lengths, skipped or repeated entries and a wrong wrap. The underrun pass separates the two pad choices, and the pause pass separates a held position from a reloaded one.

// File: rtl/audio_ring_dma.sv
module audio_ring_dma #(
  parameter int AW = 32,
  parameter int IW = 5,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_word,
  input  logic [3:0]    reg_be,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic [AW-1:0] buf_addr,
  input  logic          in_valid,
  input  logic [SW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_data,
  output logic          irq
);
  typedef enum logic [2:0] {S_IDLE, S_REQ0, S_WAIT0, S_REQ1, S_WAIT1, S_STREAM, S_DONE} st_t;
  st_t st;

  logic [AW-4:0] base_q;
  logic [IW-1:0] civ_q, lvi_q;
  logic [4:1]    sr_q;
  logic [15:0]   picb_q;
  logic [4:2]    cr_q;
  logic          ioc_q, pad_q, eq_q;
  logic [AW-1:1] badr_q;
  logic [SW-1:0] last_q;

  wire run    = cr_q[2];
  wire halted = !run || st == S_DONE;
  wire wr_cr  = reg_wr && reg_word == 2'd2 && reg_be[3];
  wire wr_rst = wr_cr && reg_wdata[25];
  wire wr_lvi = reg_wr && reg_word == 2'd1 && reg_be[1];
  wire wr_sr  = reg_wr && reg_word == 2'd1 && reg_be[2];
  wire rsp1   = st == S_WAIT1 && mem_rsp_valid;
  wire fire   = out_valid && out_ready;
  wire finish = (st == S_STREAM && fire && picb_q == 16'd1) ||
                (rsp1 && mem_rsp_data[15:0] == 16'd0);
  wire fin_ioc = (st == S_STREAM) ? ioc_q : mem_rsp_data[31];
  wire at_last = civ_q == lvi_q;
  wire [IW-1:0] lvi_n = wr_lvi ? reg_wdata[8+IW-1:8] : lvi_q;
  wire [IW-1:0] civ_n;
  wire [4:1] sr_set = {fire && !in_valid, finish && fin_ioc, finish && at_last,
                       (civ_n == lvi_n) && !eq_q};
  wire [4:1] sr_clr = wr_sr ? reg_wdata[20:17] : 4'd0;
  logic unused_bits;

  assign civ_n = wr_rst ? '0 : (finish && !at_last) ? civ_q + 1'b1 :
                 (st == S_DONE && run && !at_last) ? civ_q + 1'b1 : civ_q;
  assign unused_bits   = ^{reg_wdata[2:0], mem_rsp_data[29:16], mem_rsp_data[0]};
  assign mem_req_valid = run && (st == S_REQ0 || st == S_REQ1);
  assign mem_req_addr  = {base_q + (AW-3)'(civ_q), st == S_REQ1, 2'b00};
  assign buf_addr      = {badr_q, 1'b0};
  assign out_valid     = run && st == S_STREAM;
  assign in_ready      = fire;
  assign out_data      = in_valid ? in_data : (pad_q ? last_q : '0);
  assign irq = (sr_q[3] && cr_q[4]) || (sr_q[2] && cr_q[3]) || (sr_q[4] && cr_q[2]);

  always_comb begin
    reg_rdata = '0;
    case (reg_word)
      2'd0: reg_rdata = {base_q, 3'b000};
      2'd1: reg_rdata = {8'd0, 3'd0, sr_q, halted, 3'd0, lvi_q, 3'd0, civ_q};
      2'd2: reg_rdata = {3'd0, cr_q, 2'b00, 8'd0, picb_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; base_q <= '0; civ_q <= '0; lvi_q <= '0; sr_q <= '0;
      picb_q <= '0; cr_q <= '0; ioc_q <= 1'b0; pad_q <= 1'b0; eq_q <= 1'b1;
      badr_q <= '0; last_q <= '0;
    end else begin
      if (reg_wr && reg_word == 2'd0 && reg_be == 4'hF) base_q <= reg_wdata[31:3];
      lvi_q <= lvi_n;
      civ_q <= civ_n;
      eq_q  <= civ_n == lvi_n;
      sr_q  <= (sr_q & ~sr_clr) | sr_set;
      if (fire) last_q <= out_data;
      if (wr_rst) begin
        cr_q <= '0; picb_q <= '0; st <= S_IDLE;
      end else begin
        if (wr_cr) cr_q <= reg_wdata[28:26];
        case (st)
          S_IDLE:  if (run) st <= S_REQ0;
          S_REQ0:  if (mem_req_valid && mem_req_ready) st <= S_WAIT0;
          S_WAIT0: if (mem_rsp_valid) begin
                     badr_q <= mem_rsp_data[31:1];
                     st <= S_REQ1;
                   end
          S_REQ1:  if (mem_req_valid && mem_req_ready) st <= S_WAIT1;
          S_WAIT1: if (mem_rsp_valid) begin
                     ioc_q  <= mem_rsp_data[31];
                     pad_q  <= mem_rsp_data[30];
                     picb_q <= mem_rsp_data[15:0];
                     st <= finish ? (at_last ? S_DONE : S_REQ0) : S_STREAM;
                   end
          S_STREAM: if (fire) begin
                     picb_q <= picb_q - 16'd1;
                     if (finish) st <= at_last ? S_DONE : S_REQ0;
                   end
          S_DONE:  if (run && !at_last) st <= S_REQ0;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_picb_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STREAM && fire && picb_q > 16'd1 && !wr_rst) |=> picb_q == $past(picb_q) - 16'd1);
  assert_civ_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rst |=> (civ_q == $past(civ_q) || civ_q == $past(civ_q) + 1'b1));
  assert_halt_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_DONE) |-> sr_q[2]);
  assert_out_needs_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cr_q[2]);
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sr_q[4] || sr_q[3] || sr_q[2]));
  assert_fetch_or_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, out_valid}));
endmodule

// File: tb/audio_ring_dma_tb.sv
module audio_ring_dma_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_word = 2'd0;
  logic [3:0] reg_be = 4'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req_valid, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_rsp_data = '0, buf_addr;
  logic in_valid = 1'b1, in_ready, out_valid, out_ready = 1'b1, irq;
  logic [15:0] in_data = 16'h1111, out_data;

  localparam logic [31:0] BASE = 32'h0000_4000;
  int checks = 0, errors = 0;
  int cnt[32], exp_cnt[32];
  logic [15:0] last_sent = '0;
  logic [31:0] req_hist[2];

  always #5 clk = ~clk;

  audio_ring_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(1'b1), .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .buf_addr(buf_addr), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .irq(irq));

  function automatic int dlen(int i);
    return (i == 5) ? 0 : (i % 4) + 3;
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    int i;
    i = int'((a - BASE) >> 3) % 32;
    if (a[2]) return {(i % 3 == 0), (i % 2 == 1), 14'd0, 16'(dlen(i))};
    return 32'h1000_0001 + (32'(i) << 8);
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid;
    mem_rsp_data  <= mem_word(mem_req_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req_valid) begin
      chk(mem_req_addr[1:0] == 2'b00 && mem_req_addr >= BASE && mem_req_addr < BASE + 256,
          "R2 request address", mem_req_addr, BASE);
      req_hist[0] = req_hist[1];
      req_hist[1] = mem_req_addr;
    end
    if (rst_n && out_valid && out_ready) begin
      logic [15:0] e;
      int idx;
      idx = int'(buf_addr[12:8]);
      if (in_valid) e = in_data;
      else e = (idx % 2 == 1) ? last_sent : 16'h0000;
      chk(out_data == e && buf_addr[0] == 1'b0 && buf_addr[31:13] == 19'h08000,
          in_valid ? "R4 sample data / R3 address" : "R10 pad word", {buf_addr[15:0], out_data}, {16'h0, e});
      cnt[idx]++;
      last_sent = out_data;
    end
  end

  task automatic wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_word = w; reg_be = be; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_be = 4'd0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    @(posedge clk); #2;
    reg_word = w; #1;
    d = reg_rdata;
  endtask

  task automatic set_lvi(input int v);  wr(2'd1, 4'b0010, 32'(v) << 8); endtask
  task automatic set_cr(input logic [7:0] v); wr(2'd2, 4'b1000, {v, 24'd0}); endtask
  task automatic clr_sr(input logic [7:0] v); wr(2'd1, 4'b0100, {8'd0, v, 16'd0}); endtask

  task automatic wait_halt();
    logic [31:0] d;
    repeat (3) @(posedge clk);
    for (int k = 0; k < 3000; k++) begin
      rd(2'd1, d);
      if (d[16]) break;
    end
  endtask

  task automatic add_run(input int from, input int to);
    int i;
    i = from;
    forever begin
      exp_cnt[i] += dlen(i);
      if (i == to) break;
      i = (i + 1) % 32;
    end
  endtask

  task automatic chk_counts(input string tag);
    for (int i = 0; i < 32; i++) chk(cnt[i] == exp_cnt[i], tag, cnt[i], exp_cnt[i]);
  endtask

  initial begin
    repeat (80000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 32; i++) begin cnt[i] = 0; exp_cnt[i] = 0; end
    repeat (3) @(posedge clk); #2; rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, d); chk(d == 0, "R1 base", d, 0);
    rd(2'd1, d); chk(d == 32'h0001_0000, "R1 index/status", d, 32'h0001_0000);
    rd(2'd2, d); chk(d == 0, "R1 control/position", d, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R2 base low bits ignored; first run 0..3
    wr(2'd0, 4'hF, BASE | 32'h7);
    rd(2'd0, d); chk(d == BASE, "R2 base readback", d, BASE);
    set_lvi(3); in_valid = 1'b1; in_data = 16'h1111;
    set_cr(8'h1C); wait_halt(); add_run(0, 3);
    rd(2'd1, d);
    chk(d == 32'h000F_0303, "R7 R6 R8 halt at last valid", d, 32'h000F_0303);
    chk(req_hist[0] == BASE + 24 && req_hist[1] == BASE + 28, "R2 descriptor pair",
        req_hist[1], BASE + 28);
    chk_counts("R4 lengths first run");

    // R11 interrupt enables, R9 clear
    set_cr(8'h08); #1 chk(irq == 1'b1, "R11 last-valid irq", irq, 1);
    clr_sr(8'h04); #1 chk(irq == 1'b0, "R11 completion not enabled", irq, 0);
    set_cr(8'h10); #1 chk(irq == 1'b1, "R11 completion irq", irq, 1);
    clr_sr(8'h1F);
    rd(2'd1, d); chk(d[23:16] == 8'h01, "R9 write-one clear", d[23:16], 8'h01);
    chk(irq == 1'b0, "R11 irq after clear", irq, 0);

    // R5 wrap from 4 through 31 to 2
    set_lvi(2); set_cr(8'h1C); wait_halt(); add_run(4, 2);
    rd(2'd1, d); chk(d == 32'h000F_0202, "R5 R7 halt after wrap", d, 32'h000F_0202);
    chk_counts("R5 R14 counts after wrap");
    clr_sr(8'h1E);

    // R10 underrun, pad-last (3) then pad-zero (4)
    in_valid = 1'b0; in_data = 16'hAAAA;
    set_lvi(4); wait_halt(); add_run(3, 4);
    rd(2'd1, d); chk(d[23:16] == 8'h1F, "R10 underrun flag", d[23:16], 8'h1F);
    chk(cnt[3] == exp_cnt[3] && cnt[4] == exp_cnt[4], "R10 underrun counts", cnt[4], exp_cnt[4]);
    clr_sr(8'h1E); in_valid = 1'b1; in_data = 16'h2222;

    // R8 match caused by a last-valid write
    set_cr(8'h00);
    set_lvi(6); set_lvi(4);
    rd(2'd1, d); chk(d[23:16] == 8'h03, "R8 match on write", d[23:16], 8'h03);
    clr_sr(8'h02);
    rd(2'd1, d); chk(d[23:16] == 8'h01, "R9 clear match bit", d[23:16], 8'h01);

    // R12 pause, R14 zero length, R6 no completion flag
    out_ready = 1'b0; set_lvi(6); set_cr(8'h04);
    repeat (12) @(posedge clk);
    rd(2'd2, d); chk(d[15:0] == 16'd5, "R4 position load", d[15:0], 5);
    rd(2'd1, d); chk(d[4:0] == 5'd6, "R14 zero length skipped", d[4:0], 6);
    chk(d[19] == 1'b0, "R6 no completion flag", d[19], 0);
    @(posedge clk); #2 out_ready = 1'b1;
    @(posedge clk); #2 out_ready = 1'b0;
    rd(2'd2, d); chk(d[15:0] == 16'd4, "R4 position step", d[15:0], 4);
    set_cr(8'h00);
    rd(2'd2, d); chk(d[31:24] == 8'h00, "R12 control reads zero", d[31:24], 0);
    rd(2'd1, d); chk(d[16] == 1'b1, "R12 halted while paused", d[16], 1);
    out_ready = 1'b1; repeat (8) @(posedge clk);
    rd(2'd2, d); chk(d[15:0] == 16'd4, "R12 position held", d[15:0], 4);
    chk(cnt[6] == exp_cnt[6] + 1, "R12 no samples while paused", cnt[6], exp_cnt[6] + 1);
    set_cr(8'h04); wait_halt(); add_run(5, 6);
    rd(2'd1, d); chk(d[19] == 1'b1 && d[4:0] == 5'd6, "R6 completion flag", d, 32'h0008_0606);
    chk(cnt[6] == exp_cnt[6] && cnt[5] == 0, "R12 R14 resumed counts", cnt[6], exp_cnt[6]);

    // R13 engine reset
    set_cr(8'h02);
    rd(2'd1, d); chk(d[4:0] == 5'd0 && d[12:8] == 5'd6 && d[16], "R13 index cleared", d, 32'h0001_0600);
    rd(2'd2, d); chk(d == 0, "R13 position/control cleared", d, 0);
    set_lvi(0); set_cr(8'h04); wait_halt(); add_run(0, 0);
    rd(2'd1, d); chk(d[4:0] == 5'd0 && d[18], "R13 restart from index 0", d, 32'h0004_0000);
    chk_counts("R4 final counts");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule